// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the storage and output stage that sits after a programmable AND/OR array. It receives a combinational sum-of-products term. Configuration inputs decide what the block does with that term. It can pass the term straight to the output. It can also capture the term in a flip-flop that behaves as a D, T, JK or SR type.

The flip-flop has two possible clocks: a product-term clock, or a dedicated external clock pin. It also has an active-high preset and an active-high clear. The clear is the OR of two product-term inputs, and each of those inputs has its own enable. An output multiplexer picks either the stored value or the combinational term. The chosen value drives both the pin output and a feedback line into the array.

The block runs on one system clock, which samples both clock sources. A rising edge on the selected source becomes a one-cycle capture enable. Preset and clear act at once on the output, in the same cycle, without waiting for an edge. There is no streaming data path here, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `pld_out_cell`

## Requirements
- R1: After reset, with the registered output selected, `pin_out` is 0 and `illegal_sr` is 0.
- R2: With `cfg_reg_sel`=0, `pin_out` equals `sop_a` in the same cycle, whatever the flip-flop holds.
- R3: `fb_out` always equals `pin_out`.
- R4: With `cfg_ff_type`=00 (D), a capture loads `sop_a`.
- R5: With `cfg_ff_type`=01 (T), a capture inverts the state when `sop_a`=1 and keeps it when `sop_a`=0.
- R6: With `cfg_ff_type`=10 (JK, J=`sop_a`, K=`sop_b`), a capture gives: J=K=0 hold, J=1 K=0 set, J=0 K=1 reset, J=K=1 toggle.
- R7: With `cfg_ff_type`=11 (SR, S=`sop_a`, R=`sop_b`), a capture gives: S=R=0 hold, S=1 R=0 set, S=0 R=1 reset, S=R=1 hold. `illegal_sr` is high exactly when the mode is SR and both inputs are 1.
- R8: A capture happens only on a 0-to-1 change of the selected clock source. `cfg_clk_ext`=1 selects `ext_clk` and 0 selects `pt_clk`. Edges on the other source have no effect, and a source that stays high causes no further capture.
- R9: `pt_preset`=1 forces the stored value to 1 in the same cycle, with no clock edge needed. The 1 remains after preset is released.
- R10: Clear is `pt_clr[i]` AND `cfg_clr_en[i]`, ORed over i=0,1. It forces the stored value to 0 in the same cycle, and it wins over preset. A clear term whose enable is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ff_type | input | 2 | Flip-flop kind: 00 D, 01 T, 10 JK, 11 SR |
| cfg_reg_sel | input | 1 | 1 selects the stored value, 0 selects the combinational term |
| cfg_clk_ext | input | 1 | 1 selects ext_clk as clock, 0 selects pt_clk |
| cfg_clr_en | input | 2 | Enable for each clear product term |
| sop_a | input | 1 | Main sum-of-products term (D, T, J or S) |
| sop_b | input | 1 | Second sum-of-products term (K or R) |
| pt_clk | input | 1 | Product-term clock |
| ext_clk | input | 1 | Dedicated external clock pin |
| pt_preset | input | 1 | Active-high preset product term |
| pt_clr | input | 2 | Active-high clear product terms |
| pin_out | output | 1 | Output multiplexer result toward the pin |
| fb_out | output | 1 | Output multiplexer result fed back to the array |
| illegal_sr | output | 1 | SR mode with both inputs high |

## Verification
The combinational path, `illegal_sr`, preset and clear all show on the outputs in the same cycle they are driven. The bench checks them one time step after it drives them, with no system edge in between. A capture is due at the first system edge after the selected source is seen going high, so the bench raises the source at a falling edge and checks one full clock later. It then holds the source high for one more cycle and checks again, which confirms that a level alone does not capture again. Each sweep case first pulses the unselected source and checks that the state has not changed.

// File: rtl/pld_cell_pkg.sv
package pld_cell_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'b00,
    FF_T  = 2'b01,
    FF_JK = 2'b10,
    FF_SR = 2'b11
  } ff_kind_e;
endpackage

// File: rtl/pld_rise_detect.sv
module pld_rise_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_src
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= src[i];
      end
      assign rise[i] = src[i] & ~prev_q;

      // R8
      single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |=> !rise[i]);
    end
  endgenerate
endmodule

// File: rtl/pld_ff_next.sv
module pld_ff_next
  import pld_cell_pkg::*;
(
  input  ff_kind_e kind,
  input  logic     q,
  input  logic     in_a,
  input  logic     in_b,
  output logic     q_nxt,
  output logic     sr_bad
);
  always_comb begin
    sr_bad = 1'b0;
    unique case (kind)
      FF_D:  q_nxt = in_a;
      FF_T:  q_nxt = q ^ in_a;
      FF_JK: q_nxt = (in_a & ~q) | (~in_b & q);
      FF_SR: begin
        sr_bad = in_a & in_b;
        if (in_a && !in_b)      q_nxt = 1'b1;
        else if (!in_a && in_b) q_nxt = 1'b0;
        else                    q_nxt = q;
      end
      default: q_nxt = q;
    endcase
  end
endmodule

// File: rtl/pld_clr_combine.sv
module pld_clr_combine #(
  parameter int NCLR = 2
) (
  input  logic [NCLR-1:0] terms,
  input  logic [NCLR-1:0] en,
  output logic            clr
);
  logic [NCLR-1:0] gated;
  genvar i;
  generate
    for (i = 0; i < NCLR; i++) begin : g_term
      assign gated[i] = terms[i] & en[i];
    end
  endgenerate
  assign clr = |gated;
endmodule

// File: rtl/pld_out_cell.sv
module pld_out_cell
  import pld_cell_pkg::*;
#(
  parameter int NCLR = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_ff_type,
  input  logic            cfg_reg_sel,
  input  logic            cfg_clk_ext,
  input  logic [NCLR-1:0] cfg_clr_en,
  input  logic            sop_a,
  input  logic            sop_b,
  input  logic            pt_clk,
  input  logic            ext_clk,
  input  logic            pt_preset,
  input  logic [NCLR-1:0] pt_clr,
  output logic            pin_out,
  output logic            fb_out,
  output logic            illegal_sr
);
  localparam int NSRC = 2;

  logic [NSRC-1:0] src_vec, rise_vec;
  logic            clk_en, clr_any, q_reg, q_nxt, q_eff, mux_out;
  ff_kind_e        kind;

  assign kind    = ff_kind_e'(cfg_ff_type);
  assign src_vec = {ext_clk, pt_clk};

  pld_rise_detect #(.W(NSRC)) u_rise (
    .clk(clk), .rst_n(rst_n), .src(src_vec), .rise(rise_vec)
  );
  assign clk_en = rise_vec[cfg_clk_ext];

  pld_clr_combine #(.NCLR(NCLR)) u_clr (
    .terms(pt_clr), .en(cfg_clr_en), .clr(clr_any)
  );

  pld_ff_next u_next (
    .kind(kind), .q(q_reg), .in_a(sop_a), .in_b(sop_b),
    .q_nxt(q_nxt), .sr_bad(illegal_sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q_reg <= 1'b0;
    else if (clr_any)   q_reg <= 1'b0;
    else if (pt_preset) q_reg <= 1'b1;
    else if (clk_en)    q_reg <= q_nxt;
  end

  always_comb begin
    if (clr_any)        q_eff = 1'b0;
    else if (pt_preset) q_eff = 1'b1;
    else                q_eff = q_reg;
  end

  assign mux_out = cfg_reg_sel ? q_eff : sop_a;
  assign pin_out = mux_out;
  assign fb_out  = mux_out;

  // R8
  hold_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !clr_any && !pt_preset) |=> $stable(q_reg));

  // R4
  d_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !clr_any && !pt_preset && kind == FF_D) |=> (q_reg == $past(sop_a)));

  // R7
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !clr_any && !pt_preset && kind == FF_SR && sop_a && sop_b) |=> $stable(q_reg));

  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg_sel && clr_any) |-> !pin_out);

  // R2
  comb_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_reg_sel |-> (pin_out == sop_a));
endmodule

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_ff_type = 2'b00;
  logic cfg_reg_sel = 1'b1, cfg_clk_ext = 1'b0;
  logic [1:0] cfg_clr_en = 2'b01;
  logic sop_a = 1'b0, sop_b = 1'b0, pt_clk = 1'b0, ext_clk = 1'b0, pt_preset = 1'b0;
  logic [1:0] pt_clr = 2'b00;
  logic pin_out, fb_out, illegal_sr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_out_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ff_type(cfg_ff_type), .cfg_reg_sel(cfg_reg_sel),
    .cfg_clk_ext(cfg_clk_ext), .cfg_clr_en(cfg_clr_en), .sop_a(sop_a), .sop_b(sop_b),
    .pt_clk(pt_clk), .ext_clk(ext_clk), .pt_preset(pt_preset), .pt_clr(pt_clr),
    .pin_out(pin_out), .fb_out(fb_out), .illegal_sr(illegal_sr)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model_next(input int kind, input logic q, input logic a, input logic b);
    case (kind)
      0: return a;
      1: return q ^ a;
      2: return (a & ~q) | (~b & q);
      default: return a ? (b ? q : 1'b1) : (b ? 1'b0 : q);
    endcase
  endfunction

  task automatic set_src(input logic ext, input logic v);
    if (ext) ext_clk = v; else pt_clk = v;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%b expected=%b", 1'b0, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic exp_q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pin_out", pin_out, 1'b0);
    check("R1 illegal_sr", illegal_sr, 1'b0);

    // R2/R3 combinational path while stored value is 1
    pt_preset = 1'b1; @(negedge clk); pt_preset = 1'b0;
    cfg_reg_sel = 1'b0;
    for (int v = 0; v < 2; v++) begin
      sop_a = v[0]; #1;
      check("R2 comb pass", pin_out, v[0]);
      check("R3 feedback", fb_out, v[0]);
      @(negedge clk);
    end
    cfg_reg_sel = 1'b1; sop_a = 1'b0; #1;
    check("R2 stored kept", pin_out, 1'b1);
    @(negedge clk);

    // Sweep: clock source x kind x initial state x inputs (R4-R8)
    for (int ext = 0; ext < 2; ext++) begin
      for (int kind = 0; kind < 4; kind++) begin
        for (int q0 = 0; q0 < 2; q0++) begin
          for (int ab = 0; ab < 4; ab++) begin
            cfg_clk_ext = ext[0];
            cfg_ff_type = kind[1:0];
            if (q0 != 0) pt_preset = 1'b1; else pt_clr = 2'b01;
            @(negedge clk);
            pt_preset = 1'b0; pt_clr = 2'b00;
            sop_a = ab[1]; sop_b = ab[0]; #1;
            check("R7 illegal flag", illegal_sr, (kind == 3) && ab == 3);
            // R8 other source ignored
            set_src(!ext[0], 1'b1); @(negedge clk);
            check("R8 other source", pin_out, q0[0]);
            set_src(!ext[0], 1'b0); @(negedge clk);
            exp_q = model_next(kind, q0[0], ab[1], ab[0]);
            set_src(ext[0], 1'b1); @(negedge clk);
            case (kind)
              0: check("R4 D capture", pin_out, exp_q);
              1: check("R5 T capture", pin_out, exp_q);
              2: check("R6 JK capture", pin_out, exp_q);
              default: check("R7 SR capture", pin_out, exp_q);
            endcase
            check("R3 feedback", fb_out, exp_q);
            @(negedge clk);
            check("R8 level no recapture", pin_out, exp_q);
            set_src(ext[0], 1'b0); @(negedge clk);
          end
        end
      end
    end

    // R9 preset acts at once and persists
    cfg_ff_type = 2'b00; sop_a = 1'b0; sop_b = 1'b0;
    pt_clr = 2'b01; @(negedge clk); pt_clr = 2'b00; @(negedge clk);
    pt_preset = 1'b1; #1;
    check("R9 preset immediate", pin_out, 1'b1);
    @(negedge clk); pt_preset = 1'b0; @(negedge clk);
    check("R9 preset persists", pin_out, 1'b1);

    // R10 disabled clear term, enabled clear, clear beats preset
    cfg_clr_en = 2'b10; pt_clr = 2'b01; #1;
    check("R10 disabled term", pin_out, 1'b1);
    @(negedge clk); pt_clr = 2'b00; #1;
    check("R10 disabled term after", pin_out, 1'b1);
    pt_clr = 2'b10; #1;
    check("R10 enabled term immediate", pin_out, 1'b0);
    @(negedge clk); pt_clr = 2'b00; @(negedge clk);
    check("R10 clear persists", pin_out, 1'b0);
    pt_preset = 1'b1; pt_clr = 2'b10; #1;
    check("R10 clear beats preset", pin_out, 1'b0);
    @(negedge clk); pt_clr = 2'b00; pt_preset = 1'b0; @(negedge clk);
    check("R10 after both", pin_out, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule